// File: doc/BRIEF.md
# Switching-Cycle Overcurrent and Overvoltage Switch Gate

This block sits beside one channel of a synchronous buck converter and decides, clock by clock, whether the high-side and the low-side power switches may conduct. It never sees analog quantities. It reads a cycle tick from the oscillator and single-bit flags from the comparators: a peak-current trip, a low-side source-current-over flag taken as the cycle closes, a low-side sink-current-over flag, an overvoltage hit and an overvoltage clear. From these it produces the two switch permits, a request that the ramp generator restart soft start, and a hiccup status bit.

Repeated overcurrent is tracked by a counter of consecutive faulted cycles. When that count reaches its limit, the block holds both switches off for a fixed number of cycle ticks and then asks for a fresh soft start. If the fault is still there, the counter fills again and the block goes back into hiccup. Overvoltage has its own two-phase latch. In the first phase the low side discharges the output until the sink limit trips. In the second phase both switches stay off until the clear flag arrives.

All pins are plain control and status levels. There is no streaming data path, so the block has no valid/ready handshake.

Top module: `ocp_hiccup_ctrl`

## Requirements
- R1: While reset is held and directly after it, hs_on=0, ls_on=0, hiccup=0 and ss_restart=1. The fault counter is zero.
- R2: A cycle_tick in normal operation with ls_src_over=0 gives hs_on=1 and ls_on=0 from the following clock.
- R3: peak_trip while hs_on=1 gives hs_on=0 and ls_on=1 on the next clock, and adds one to the fault count.
- R4: ls_src_over=1 at a cycle_tick keeps the high side off and the low side on for the whole new cycle, and adds one to the fault count.
- R5: A cycle_tick that closes a cycle with no peak trip and no low-side carry-over sets the fault count to zero.
- R6: The increment that takes the fault count to OC_LIMIT sets hiccup=1 and forces both permits to 0 from the next clock. The count saturates at OC_LIMIT.
- R7: Hiccup lasts exactly HICCUP_TICKS cycle ticks. On the last of them, hiccup falls, ss_restart rises and the count clears. Switching resumes at the tick after that. ss_restart falls on the clock after ss_done is seen outside hiccup.
- R8: ls_sink_over while ls_on=1 turns both permits off until the next cycle_tick.
- R9: ov_hit gives hs_on=0 and ls_on=1 until ls_sink_over. Both permits then stay 0 until ov_clear, and switching restarts at the first cycle_tick after the clear.
- R10: While an overvoltage phase is active, peak trips and ticks are ignored and the count is frozen. While in hiccup, ov_hit is ignored.
- R11: hs_on and ls_on are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cycle_tick | input | 1 | One-clock pulse that ends one switching cycle and starts the next |
| peak_trip | input | 1 | High-side peak-current comparator fired |
| ls_src_over | input | 1 | Low-side source current above its limit, valid at cycle_tick |
| ls_sink_over | input | 1 | Low-side sink current above its limit |
| ov_hit | input | 1 | Feedback above the overvoltage level |
| ov_clear | input | 1 | Feedback back down to the overvoltage release level |
| ss_done | input | 1 | Soft-start ramp finished |
| hs_on | output | 1 | High-side switch permit |
| ls_on | output | 1 | Low-side switch permit |
| ss_restart | output | 1 | Request to run soft start again |
| hiccup | output | 1 | Hiccup off-period in progress |

## Verification
The bench builds the block with OC_LIMIT=4 and HICCUP_TICKS=12 instead of 10 and 4096. A short run of consecutive faults is then enough to enter hiccup, and a complete hiccup period with its soft-start retry fits into a few dozen clocks. Both random and directed stimulus can therefore reach re-entry into hiccup, an overvoltage arriving during hiccup, and a counter reset that lands one fault short of the limit.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [1:0] {
    OVP_IDLE = 2'd0,
    OVP_SINK = 2'd1,
    OVP_HOLD = 2'd2
  } ovp_phase_e;
endpackage

// File: rtl/ocp_fault_counter.sv
module ocp_fault_counter #(
  parameter int LIMIT = 10,
  parameter int CW    = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
  end

  // R6
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= TOP);
endmodule

// File: rtl/ocp_hiccup_timer.sv
module ocp_hiccup_timer #(
  parameter int TICKS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic active,
  output logic done
);
  localparam int TW = (TICKS > 2) ? $clog2(TICKS) : 1;
  localparam logic [TW-1:0] LAST = TW'(TICKS - 1);

  logic [TW-1:0] tcnt;

  assign done = active && tick && (tcnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      tcnt   <= '0;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1;
        tcnt   <= '0;
      end
    end else if (tick) begin
      if (tcnt == LAST) begin
        active <= 1'b0;
        tcnt   <= '0;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  // R7
  tcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n) tcnt <= LAST);
endmodule

// File: rtl/ocp_ov_latch.sv
module ocp_ov_latch
  import ocp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ov_hit,
  input  logic       sink_over,
  input  logic       ov_clear,
  input  logic       blocked,
  output ovp_phase_e phase
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= OVP_IDLE;
    else begin
      unique case (phase)
        OVP_IDLE: if (ov_hit && !blocked) phase <= OVP_SINK;
        OVP_SINK: if (sink_over)          phase <= OVP_HOLD;
        OVP_HOLD: if (ov_clear)           phase <= OVP_IDLE;
        default:                          phase <= OVP_IDLE;
      endcase
    end
  end

  // R9
  ov_hold_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == OVP_HOLD) |-> ($past(phase) inside {OVP_SINK, OVP_HOLD}));
endmodule

// File: rtl/ocp_hiccup_ctrl.sv
module ocp_hiccup_ctrl
  import ocp_pkg::*;
#(
  parameter int OC_LIMIT     = 10,
  parameter int HICCUP_TICKS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cycle_tick,
  input  logic peak_trip,
  input  logic ls_src_over,
  input  logic ls_sink_over,
  input  logic ov_hit,
  input  logic ov_clear,
  input  logic ss_done,
  output logic hs_on,
  output logic ls_on,
  output logic ss_restart,
  output logic hiccup
);
  localparam int CW = $clog2(OC_LIMIT + 1);
  localparam logic [CW-1:0] NEAR = CW'(OC_LIMIT - 1);

  logic [CW-1:0] oc_cnt;
  logic          cnt_inc, cnt_clr, hic_start, hic_done, hic_active;
  logic          trip_seen, trip_d, hs_d, ls_d, ov_go;
  ovp_phase_e    ov_phase;

  ocp_fault_counter #(.LIMIT(OC_LIMIT), .CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .cnt(oc_cnt));

  ocp_hiccup_timer #(.TICKS(HICCUP_TICKS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(hic_start), .tick(cycle_tick),
    .active(hic_active), .done(hic_done));

  ocp_ov_latch u_ov (
    .clk(clk), .rst_n(rst_n), .ov_hit(ov_hit), .sink_over(ls_sink_over),
    .ov_clear(ov_clear), .blocked(hic_active), .phase(ov_phase));

  assign ov_go  = ov_hit && (ov_phase == OVP_IDLE) && !hic_active;
  assign hiccup = hic_active;

  always_comb begin
    cnt_inc   = 1'b0;
    cnt_clr   = 1'b0;
    hic_start = 1'b0;
    hs_d      = hs_on;
    ls_d      = ls_on;
    trip_d    = trip_seen;
    if (hic_active) begin
      hs_d = 1'b0; ls_d = 1'b0; trip_d = 1'b0;
      cnt_clr = hic_done;
    end else if (ov_go) begin
      hs_d = 1'b0; ls_d = 1'b1; trip_d = 1'b0;
    end else if (ov_phase == OVP_SINK) begin
      hs_d = 1'b0; ls_d = !ls_sink_over;
    end else if (ov_phase == OVP_HOLD) begin
      hs_d = 1'b0; ls_d = 1'b0;
    end else if (cycle_tick) begin
      trip_d = 1'b0;
      if (ls_src_over) begin
        cnt_inc = 1'b1;
        hs_d = 1'b0; ls_d = 1'b1;
        if (oc_cnt == NEAR) begin
          hic_start = 1'b1; ls_d = 1'b0;
        end
      end else begin
        cnt_clr = !trip_seen;
        hs_d = 1'b1; ls_d = 1'b0;
      end
    end else if (peak_trip && hs_on) begin
      cnt_inc = 1'b1; trip_d = 1'b1;
      hs_d = 1'b0; ls_d = 1'b1;
      if (oc_cnt == NEAR) begin
        hic_start = 1'b1; ls_d = 1'b0;
      end
    end else if (ls_sink_over && ls_on) begin
      hs_d = 1'b0; ls_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_on      <= 1'b0;
      ls_on      <= 1'b0;
      trip_seen  <= 1'b0;
      ss_restart <= 1'b1;
    end else begin
      hs_on     <= hs_d;
      ls_on     <= ls_d;
      trip_seen <= trip_d;
      if (hic_done)                  ss_restart <= 1'b1;
      else if (ss_done && !hic_active) ss_restart <= 1'b0;
    end
  end

  // R11
  no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_on && ls_on));
  // R6
  hiccup_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hiccup |-> (!hs_on && !ls_on));
  // R7
  retry_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hiccup) |-> ss_restart);
  // R9
  ov_hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_phase == OVP_HOLD) |-> !hs_on);
  // R10
  ov_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ov_phase) == OVP_SINK && ov_phase == OVP_SINK) |-> $stable(oc_cnt));
endmodule

// File: tb/ocp_hiccup_ctrl_test.sv
module ocp_hiccup_ctrl_test;
  localparam int LIM = 4;
  localparam int HIC = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 0, pk = 0, src = 0, snk = 0, ov = 0, clr = 0, ssd = 0;
  logic hs_on, ls_on, ss_restart, hiccup;

  int checks = 0;
  int fails  = 0;

  // bench reference state
  bit m_hs, m_ls, m_trip, m_hic, m_ss;
  int m_cnt, m_tcnt, m_ph;

  always #4 clk = ~clk;

  ocp_hiccup_ctrl #(.OC_LIMIT(LIM), .HICCUP_TICKS(HIC)) uut (
    .clk(clk), .rst_n(rst_n), .cycle_tick(cs), .peak_trip(pk),
    .ls_src_over(src), .ls_sink_over(snk), .ov_hit(ov), .ov_clear(clr),
    .ss_done(ssd), .hs_on(hs_on), .ls_on(ls_on), .ss_restart(ss_restart),
    .hiccup(hiccup));

  function automatic bit [3:0] exp_out();
    return {m_hs, m_ls, m_ss, m_hic};
  endfunction

  task automatic model_step();
    bit nhs = m_hs, nls = m_ls, ntrip = m_trip, inc = 0, zap = 0, start = 0, done = 0;
    bit go = ov && m_ph == 0 && !m_hic;
    if (m_hic) begin
      nhs = 0; nls = 0; ntrip = 0;
      done = cs && (m_tcnt == HIC - 1);
      zap = done;
    end else if (go) begin
      nhs = 0; nls = 1; ntrip = 0;
    end else if (m_ph == 1) begin
      nhs = 0; nls = !snk;
    end else if (m_ph == 2) begin
      nhs = 0; nls = 0;
    end else if (cs) begin
      ntrip = 0;
      if (src) begin
        inc = 1; nhs = 0; nls = 1;
        if (m_cnt == LIM - 1) begin start = 1; nls = 0; end
      end else begin
        zap = !m_trip; nhs = 1; nls = 0;
      end
    end else if (pk && m_hs) begin
      inc = 1; ntrip = 1; nhs = 0; nls = 1;
      if (m_cnt == LIM - 1) begin start = 1; nls = 0; end
    end else if (snk && m_ls) begin
      nhs = 0; nls = 0;
    end
    if (done) m_ss = 1;
    else if (ssd && !m_hic) m_ss = 0;
    if (m_hic) begin
      if (cs) begin
        if (m_tcnt == HIC - 1) begin m_hic = 0; m_tcnt = 0; end
        else m_tcnt++;
      end
    end else if (start) begin
      m_hic = 1; m_tcnt = 0;
    end
    if (go) m_ph = 1;
    else if (m_ph == 1 && snk) m_ph = 2;
    else if (m_ph == 2 && clr) m_ph = 0;
    if (zap) m_cnt = 0;
    else if (inc && m_cnt < LIM) m_cnt++;
    m_hs = nhs; m_ls = nls; m_trip = ntrip;
  endtask

  task automatic compare(string tag);
    checks++;
    if ({hs_on, ls_on, ss_restart, hiccup} !== exp_out()) begin
      fails++;
      $display("FAIL %s: {hs,ls,ss,hic} actual=%b expected=%b at %0t",
               tag, {hs_on, ls_on, ss_restart, hiccup}, exp_out(), $time);
    end
    checks++;
    if (hs_on && ls_on) begin
      fails++;
      $display("FAIL R11: hs=%b ls=%b expected not both 1", hs_on, ls_on);
    end
  endtask

  task automatic step(string tag, bit c, bit p, bit s, bit k, bit o, bit r, bit d);
    @(negedge clk);
    compare(tag);
    cs = c; pk = p; src = s; snk = k; ov = o; clr = r; ssd = d;
    model_step();
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    m_hs = 0; m_ls = 0; m_trip = 0; m_hic = 0; m_ss = 1; m_cnt = 0; m_tcnt = 0; m_ph = 0;
    repeat (3) @(negedge clk);
    checks++;
    if ({hs_on, ls_on, ss_restart, hiccup} !== 4'b0010) begin
      fails++;
      $display("FAIL R1: in reset actual=%b expected=0010", {hs_on, ls_on, ss_restart, hiccup});
    end
    rst_n = 1'b1;
    step("R1", 0,0,0,0,0,0,0);
    // R2 normal cycle start, soft start finishes
    step("R2", 1,0,0,0,0,0,1);
    step("R2", 0,0,0,0,0,0,0);
    // R3 peak trip ends high-side on-time
    step("R3", 0,1,0,0,0,0,0);
    step("R3", 0,0,0,0,0,0,0);
    // R5 three faulted cycles, a clean one, three more: no hiccup
    for (int i = 0; i < 2; i++) begin
      step("R5", 1,0,0,0,0,0,0);
      step("R5", 0,1,0,0,0,0,0);
    end
    step("R5", 1,0,0,0,0,0,0);
    step("R5", 1,0,0,0,0,0,0);
    for (int i = 0; i < LIM - 1; i++) begin
      step("R5", 0,1,0,0,0,0,0);
      step("R5", 1,0,0,0,0,0,0);
    end
    step("R5", 0,0,0,0,0,0,0);
    // R4 carry-over cycle counts; it completes the limit -> R6
    step("R4", 1,0,1,0,0,0,0);
    step("R6", 0,0,0,0,0,0,0);
    // R10 ov ignored in hiccup; R7 hiccup length and retry
    step("R10", 0,0,0,0,1,0,0);
    for (int i = 0; i < HIC; i++) step("R7", 1,0,0,0,0,0,0);
    step("R7", 0,0,0,0,0,0,0);
    step("R7", 1,0,0,0,0,0,0);
    step("R7", 0,0,0,0,0,0,1);
    step("R7", 0,0,0,0,0,0,0);
    // R8 sink-over
    step("R8", 0,1,0,0,0,0,0);
    step("R8", 0,0,0,1,0,0,0);
    step("R8", 0,0,0,0,0,0,0);
    step("R8", 1,0,0,0,0,0,0);
    // R9 overvoltage sequence with R10 trips and ticks ignored
    step("R9", 0,0,0,0,1,0,0);
    step("R10", 1,1,1,0,0,0,0);
    step("R9", 0,0,0,1,0,0,0);
    step("R10", 1,0,0,0,0,0,0);
    step("R9", 0,0,0,0,0,1,0);
    step("R9", 0,0,0,0,0,0,0);
    step("R9", 1,0,0,0,0,0,0);
    step("R9", 0,0,0,0,0,0,0);
    // R10 random interplay of all flags
    for (int i = 0; i < 6000; i++) begin
      step("R10",
           ($urandom % 4) == 0, ($urandom % 5) == 0, ($urandom % 3) == 0,
           ($urandom % 25) == 0, ($urandom % 80) == 0, ($urandom % 6) == 0,
           ($urandom % 9) == 0);
    end
    step("R10", 0,0,0,0,0,0,0);
    @(negedge clk);
    compare("R10");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule